// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sequences exception entry for a 32-bit processor core. Each cycle the pipeline presents a vector of pending exception causes, the PC of the instruction being excepted and the current interrupt-enable state. The block picks one cause, works out the handler address and, one clock later, presents a one-cycle redirect. The same cycle carries a write of the saved PC into a return-address register and a rewritten interrupt-enable value.

Two handler base registers are kept inside: a normal base and a debug base. A control register holds a remap flag. Debug causes (breakpoint, watchpoint) save the PC into the breakpoint-return register and always use the debug base. All other causes save the PC into the exception-return register and use the debug base only while remap is set. A configuration write port loads the bases and the control flag. The external interrupt cause only counts while the global enable is on.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset `redir_valid`, `ra_we` and `ie_we` are 0, the normal base is 0x0000_0000, the debug base is 0x0000_1000 and remap is 0 (all reset values are parameters).
- R2: Cause numbers are: 0 reset, 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide-by-zero, 6 external interrupt, 7 system call. `cause_pend[i]` flags cause i. When several are pending, the lowest-numbered eligible one is taken.
- R3: Cause 6 is eligible only while `ie_in[0]` (global enable) is 1. Otherwise it is ignored: no entry happens, or the next pending cause is taken.
- R4: An eligible cause sampled on a clock edge gives `redir_valid`=1 for the following cycle, with `redir_pc` = selected base + cause × 32. With nothing eligible, `redir_valid` is 0 the next cycle.
- R5: Causes 2, 4, 5, 6 and 7 set `ra_we`=1, `ra_sel`=30 (exception-return register) and `ra_data` = the sampled PC.
- R6: Causes 1 and 3 set `ra_we`=1, `ra_sel`=31 (breakpoint-return register) and `ra_data` = the sampled PC.
- R7: For causes 2, 4, 5, 6 and 7, `ie_out[1]` (exception-saved enable) becomes 1 if `ie_in[0]` is 1 and keeps `ie_in[1]` otherwise. `ie_out[2]` keeps `ie_in[2]` and `ie_out[0]` is 0. `ie_we`=1.
- R8: For causes 1 and 3, `ie_out[2]` (breakpoint-saved enable) becomes 1 if `ie_in[0]` is 1 and keeps `ie_in[2]` otherwise. `ie_out[1]` keeps `ie_in[1]` and `ie_out[0]` is 0. `ie_we`=1.
- R9: Causes 1 and 3 always use the debug base. All other causes use the debug base when remap is 1 and the normal base when it is 0.
- R10: With `cfg_we`=1, `cfg_sel` 0 writes the normal base, 1 writes the debug base and 2 writes remap from `cfg_wdata[0]`. Bits 7:0 of a written base are stored as zero. A write takes effect from the next clock edge.
- R11: Cause 0 redirects to the base chosen as in R9 for non-debug causes, plus 0. It gives `ra_we`=0, `ie_we`=1 and `ie_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_pend | input | 8 | Pending cause flags, bit i = cause i |
| pc_in | input | 32 | PC of the excepting instruction |
| ie_in | input | 3 | Enable state: bit0 global, bit1 exception-saved, bit2 breakpoint-saved |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 normal base, 1 debug base, 2 remap |
| cfg_wdata | input | 32 | Configuration write data |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Handler address |
| ra_we | output | 1 | Return-address register write enable |
| ra_sel | output | 5 | Return-address register index |
| ra_data | output | 32 | Saved PC |
| ie_we | output | 1 | Enable-register write strobe |
| ie_out | output | 3 | New enable-register value |

## Verification
Every cause is sent alone, with remap clear and then set, against bases loaded with nonzero low bytes. This separates base selection, masking and the cause-times-32 offset, and tells the two return registers apart. Mixed pending vectors check that the lowest number wins. Mixes that include the interrupt with the global enable clear show whether gating passes the choice on to a later cause or suppresses entry. All eight enable input values are run through one debug cause and one non-debug cause. This shows whether each saved bit is set, kept or wrongly overwritten, and that the other saved bit is left alone.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int CAUSE_W   = 3;
   localparam int NUM_CAUSE = 1 << CAUSE_W;

   typedef enum logic [CAUSE_W-1:0] {
      CS_RESET = 3'd0,
      CS_BREAK = 3'd1,
      CS_IBUS  = 3'd2,
      CS_WATCH = 3'd3,
      CS_DBUS  = 3'd4,
      CS_DIV0  = 3'd5,
      CS_IRQ   = 3'd6,
      CS_SCALL = 3'd7
   } exc_cause_e;

   typedef enum logic [1:0] {
      CFG_NBASE = 2'd0,
      CFG_DBASE = 2'd1,
      CFG_CTRL  = 2'd2
   } cfg_sel_e;

   localparam int IE_W   = 3;
   localparam int IE_GLB = 0;
   localparam int IE_EXC = 1;
   localparam int IE_DBG = 2;

   function automatic logic cause_is_debug(input logic [CAUSE_W-1:0] c);
      return (c == CS_BREAK) || (c == CS_WATCH);
   endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
   import exc_entry_pkg::*;
#(
   parameter int NUM   = NUM_CAUSE,
   parameter int IRQ_N = int'(CS_IRQ),
   localparam int IW   = $clog2(NUM)
) (
   input  logic [NUM-1:0] pend,
   input  logic           ie_glb,
   output logic           hit,
   output logic [IW-1:0]  idx
);

   logic [NUM-1:0] gate_mask;
   logic [NUM-1:0] eligible;

   generate
      for (genvar g = 0; g < NUM; g++) begin : g_gate
         if (g == IRQ_N) begin : g_irq
            assign gate_mask[g] = ie_glb;
         end else begin : g_plain
            assign gate_mask[g] = 1'b1;
         end
      end
   endgenerate

   assign eligible = pend & gate_mask;

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (eligible[i]) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/exc_base_regs.sv
module exc_base_regs
   import exc_entry_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          BASE_ALIGN = 8,
   parameter bit          REMAP_EN   = 1'b1,
   parameter logic [31:0] NBASE_RST  = 32'h0000_0000,
   parameter logic [31:0] DBASE_RST  = 32'h0000_1000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [1:0]      sel,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] nbase,
   output logic [XLEN-1:0] dbase,
   output logic            remap
);

   localparam logic [XLEN-1:0] LOW_MASK = XLEN'((64'd1 << BASE_ALIGN) - 64'd1);

   logic [XLEN-1:0] wmasked;
   assign wmasked = wdata & ~LOW_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nbase <= XLEN'(NBASE_RST) & ~LOW_MASK;
         dbase <= XLEN'(DBASE_RST) & ~LOW_MASK;
      end else if (we) begin
         if (sel == CFG_NBASE) nbase <= wmasked;
         if (sel == CFG_DBASE) dbase <= wmasked;
      end
   end

   generate
      if (REMAP_EN) begin : g_remap
         always_ff @(posedge clk) begin
            if (!rst_n)                        remap <= 1'b0;
            else if (we && sel == CFG_CTRL)    remap <= wdata[0];
         end
      end else begin : g_noremap
         assign remap = 1'b0;
      end
   endgenerate

   // R10
   base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((nbase & LOW_MASK) == '0) && ((dbase & LOW_MASK) == '0));

endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int VEC_SHIFT = 5,
   parameter int RIDX_W    = 5,
   parameter int EA_IDX    = 30,
   parameter int BA_IDX    = 31
) (
   input  logic [CAUSE_W-1:0] cause,
   input  logic [XLEN-1:0]    nbase,
   input  logic [XLEN-1:0]    dbase,
   input  logic               remap,
   input  logic [IE_W-1:0]    ie_cur,
   output logic [XLEN-1:0]    vec,
   output logic               ra_wr,
   output logic [RIDX_W-1:0]  ra_idx,
   output logic [IE_W-1:0]    ie_nxt
);

   logic dbg;
   logic use_dbase;

   assign dbg       = cause_is_debug(cause);
   assign use_dbase = dbg | remap;
   assign vec       = (use_dbase ? dbase : nbase) + (XLEN'(cause) << VEC_SHIFT);
   assign ra_wr     = (cause != CS_RESET);
   assign ra_idx    = dbg ? RIDX_W'(BA_IDX) : RIDX_W'(EA_IDX);

   always_comb begin
      ie_nxt = ie_cur;
      if (cause == CS_RESET) begin
         ie_nxt = '0;
      end else if (dbg) begin
         if (ie_cur[IE_GLB]) ie_nxt[IE_DBG] = 1'b1;
         ie_nxt[IE_GLB] = 1'b0;
      end else begin
         if (ie_cur[IE_GLB]) ie_nxt[IE_EXC] = 1'b1;
         ie_nxt[IE_GLB] = 1'b0;
      end
   end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          VEC_SHIFT  = 5,
   parameter int          BASE_ALIGN = 8,
   parameter int          RIDX_W     = 5,
   parameter int          EA_IDX     = 30,
   parameter int          BA_IDX     = 31,
   parameter bit          REMAP_EN   = 1'b1,
   parameter logic [31:0] NBASE_RST  = 32'h0000_0000,
   parameter logic [31:0] DBASE_RST  = 32'h0000_1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CAUSE-1:0] cause_pend,
   input  logic [XLEN-1:0]      pc_in,
   input  logic [IE_W-1:0]      ie_in,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_sel,
   input  logic [XLEN-1:0]      cfg_wdata,
   output logic                 redir_valid,
   output logic [XLEN-1:0]      redir_pc,
   output logic                 ra_we,
   output logic [RIDX_W-1:0]    ra_sel,
   output logic [XLEN-1:0]      ra_data,
   output logic                 ie_we,
   output logic [IE_W-1:0]      ie_out
);

   generate
      if ((NUM_CAUSE << VEC_SHIFT) > (1 << BASE_ALIGN)) begin : g_bad_align
         $error("vector span exceeds base alignment");
      end
      if (BASE_ALIGN >= XLEN) begin : g_bad_width
         $error("base alignment must be below XLEN");
      end
      if (EA_IDX == BA_IDX || EA_IDX >= (1 << RIDX_W) || BA_IDX >= (1 << RIDX_W)) begin : g_bad_idx
         $error("return register indices invalid");
      end
   endgenerate

   logic                hit;
   logic [CAUSE_W-1:0]  cause;
   logic [XLEN-1:0]     nbase, dbase;
   logic                remap;
   logic [XLEN-1:0]     vec;
   logic                ra_wr;
   logic [RIDX_W-1:0]   ra_idx;
   logic [IE_W-1:0]     ie_nxt;

   exc_prio #(.NUM(NUM_CAUSE), .IRQ_N(int'(CS_IRQ))) u_prio (
      .pend   (cause_pend),
      .ie_glb (ie_in[IE_GLB]),
      .hit    (hit),
      .idx    (cause)
   );

   exc_base_regs #(
      .XLEN(XLEN), .BASE_ALIGN(BASE_ALIGN), .REMAP_EN(REMAP_EN),
      .NBASE_RST(NBASE_RST), .DBASE_RST(DBASE_RST)
   ) u_bases (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .sel   (cfg_sel),
      .wdata (cfg_wdata),
      .nbase (nbase),
      .dbase (dbase),
      .remap (remap)
   );

   exc_vec_calc #(
      .XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .RIDX_W(RIDX_W),
      .EA_IDX(EA_IDX), .BA_IDX(BA_IDX)
   ) u_vec (
      .cause  (cause),
      .nbase  (nbase),
      .dbase  (dbase),
      .remap  (remap),
      .ie_cur (ie_in),
      .vec    (vec),
      .ra_wr  (ra_wr),
      .ra_idx (ra_idx),
      .ie_nxt (ie_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redir_valid <= 1'b0;
         redir_pc    <= '0;
         ra_we       <= 1'b0;
         ra_sel      <= '0;
         ra_data     <= '0;
         ie_we       <= 1'b0;
         ie_out      <= '0;
      end else begin
         redir_valid <= hit;
         ra_we       <= hit & ra_wr;
         ie_we       <= hit;
         if (hit) begin
            redir_pc <= vec;
            ra_sel   <= ra_idx;
            ra_data  <= pc_in;
            ie_out   <= ie_nxt;
         end
      end
   end

   // R3
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cause == CS_IRQ) |-> ie_in[IE_GLB]);

   // R4
   vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (redir_pc[VEC_SHIFT-1:0] == '0));

   // R5
   ra_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ra_we |-> (ra_data == $past(pc_in)));

   // R7
   ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ie_we |-> !ie_out[IE_GLB]);

   // R6
   ra_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ra_we |-> (redir_valid && (ra_sel == RIDX_W'(EA_IDX) || ra_sel == RIDX_W'(BA_IDX))));

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cause_pend = '0;
   logic [31:0] pc_in = '0;
   logic [2:0]  ie_in = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        redir_valid;
   logic [31:0] redir_pc;
   logic        ra_we;
   logic [4:0]  ra_sel;
   logic [31:0] ra_data;
   logic        ie_we;
   logic [2:0]  ie_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] m_nbase = 32'h0000_0000;
   logic [31:0] m_dbase = 32'h0000_1000;
   logic        m_remap = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   exc_entry_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cause_pend(cause_pend), .pc_in(pc_in),
      .ie_in(ie_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .redir_valid(redir_valid), .redir_pc(redir_pc), .ra_we(ra_we),
      .ra_sel(ra_sel), .ra_data(ra_data), .ie_we(ie_we), .ie_out(ie_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel == 2'd0) m_nbase = d & 32'hFFFF_FF00;
      if (sel == 2'd1) m_dbase = d & 32'hFFFF_FF00;
      if (sel == 2'd2) m_remap = d[0];
   endtask

   task automatic entry(input logic [7:0] pend, input logic [31:0] pc, input logic [2:0] ie);
      int  c;
      bit  found;
      bit  dbg;
      logic [31:0] base;
      logic [2:0]  ie_exp;
      found = 1'b0; c = 0;
      for (int i = 0; i < 8; i++) begin
         if (!found && pend[i] && !(i == 6 && !ie[0])) begin
            found = 1'b1; c = i;
         end
      end
      @(negedge clk);
      cause_pend = pend; pc_in = pc; ie_in = ie;
      @(negedge clk);
      cause_pend = '0;
      if (!found) begin
         chk("R3/R4 no redirect", 32'(redir_valid), 32'd0);
         chk("R4 no ra write", 32'(ra_we), 32'd0);
         chk("R4 no ie write", 32'(ie_we), 32'd0);
      end else begin
         dbg  = (c == 1) || (c == 3);
         base = (dbg || m_remap) ? m_dbase : m_nbase;
         chk("R2/R4 redirect valid", 32'(redir_valid), 32'd1);
         chk("R2/R4/R9 redirect pc", redir_pc, base + 32'(c) * 32);
         if (c == 0) begin
            chk("R11 no ra write", 32'(ra_we), 32'd0);
            ie_exp = 3'b000;
            chk("R11 ie value", 32'(ie_out), 32'(ie_exp));
         end else begin
            chk("R5/R6 ra write", 32'(ra_we), 32'd1);
            chk(dbg ? "R6 ra index" : "R5 ra index", 32'(ra_sel), dbg ? 32'd31 : 32'd30);
            chk("R5/R6 ra data", ra_data, pc);
            if (dbg) ie_exp = {ie[2] | ie[0], ie[1], 1'b0};
            else     ie_exp = {ie[2], ie[1] | ie[0], 1'b0};
            chk(dbg ? "R8 ie value" : "R7 ie value", 32'(ie_out), 32'(ie_exp));
         end
         chk("R7/R8/R11 ie write", 32'(ie_we), 32'd1);
      end
   endtask

   task automatic t_reset();
      chk("R1 redirect idle", 32'(redir_valid), 32'd0);
      chk("R1 ra idle", 32'(ra_we), 32'd0);
      chk("R1 ie idle", 32'(ie_we), 32'd0);
      entry(8'b0000_0001, 32'h0000_0100, 3'b001);
      entry(8'b0000_0010, 32'h0000_0104, 3'b001);
   endtask

   task automatic t_all_causes();
      cfg_write(2'd0, 32'h4000_20AB);
      cfg_write(2'd1, 32'h8000_01FF);
      cfg_write(2'd2, 32'h0000_0000);
      for (int c = 0; c < 8; c++) entry(8'(1 << c), 32'h1000_0000 + 32'(c * 4), 3'b001);
      cfg_write(2'd2, 32'h0000_0001);
      for (int c = 0; c < 8; c++) entry(8'(1 << c), 32'h2000_0000 + 32'(c * 8), 3'b011);
      cfg_write(2'd2, 32'h0000_0000);
   endtask

   task automatic t_priority();
      entry(8'b1010_1000, 32'h0000_A000, 3'b001);
      entry(8'b1111_1110, 32'h0000_A004, 3'b001);
      entry(8'b1100_0000, 32'h0000_A008, 3'b001);
      entry(8'b1011_0000, 32'h0000_A00C, 3'b000);
   endtask

   task automatic t_irq_gate();
      entry(8'b0100_0000, 32'h0000_B000, 3'b110);
      entry(8'b1100_0000, 32'h0000_B004, 3'b000);
      entry(8'b0110_0000, 32'h0000_B008, 3'b010);
   endtask

   task automatic t_ie_patterns();
      for (int v = 0; v < 8; v++) begin
         entry(8'b0010_0000, 32'h0000_C000 + 32'(v), 3'(v));
         entry(8'b0000_1000, 32'h0000_D000 + 32'(v), 3'(v));
      end
   endtask

   task automatic t_idle();
      entry(8'b0000_0000, 32'h0000_E000, 3'b111);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_all_causes();
      t_priority();
      t_irq_gate();
      t_ie_patterns();
      t_idle();
      finish_run();
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule